// File: doc/BRIEF.md
# Audio Codec Register Setup Master

This block brings an audio codec into a working state by writing a fixed list of configuration registers over a two-wire serial bus, with the block always acting as the bus master and the codec always the target. The list holds 19 entries. Each entry is a 16-bit word: the top 7 bits give a codec register address and the lower 9 bits give the value for that register.

One part of the block paces the bus, producing the serial clock and placing one bit on the data line per clock period. A second part chooses which word to send next and moves on once the word has gone out and been acknowledged. For each word the block sends one write transaction: a start condition, the 7-bit device address with the write bit, the byte `{addr[6:0], value[8]}`, the byte `value[7:0]`, and a stop condition. The data line is open-drain. The block only ever pulls it low or lets it go, and it reads the line level back on `sda_i`.

The walk through the table begins by itself when reset is released. It ends with `done` raised, or with `error` raised if the codec refuses a byte. A `start` pulse while the block is idle runs the whole table again from the first entry.

Top module: `codec_cfg_i2c`

## Requirements
- R1: While reset is held, `scl_o` is 1, `sda_oe` is 0, and `busy`, `done` and `error` are 0. The table walk starts by itself, and `busy` is 1 within two clocks of reset release.
- R2: Every transaction is a start condition followed by three bytes, each sent MSB first: `{DEV_ADDR, 1'b0}`, then entry bits [15:8] (`{addr[6:0], value[8]}`), then entry bits [7:0]. A stop condition closes it. Entry i occupies bits [16*i+15 : 16*i] of `CFG_TABLE`.
- R3: The data line changes only while `scl_o` is 0. There are two exceptions: the start condition, where the line falls while `scl_o` is 1, and the stop condition, where the line rises while `scl_o` is 1.
- R4: For every bit, `scl_o` stays 1 for exactly 2*DIV clock cycles.
- R5: During the ninth clock of every byte, `sda_oe` is 0 (the line is released), and the acknowledge is read on `sda_i` while `scl_o` is 1.
- R6: If `sda_i` reads 1 at the acknowledge, `error` becomes 1. The current transaction ends with a stop condition, no later entry is sent, and `done` stays 0.
- R7: Once the 19th entry has been acknowledged and its stop sent, `done` becomes 1 and `busy` becomes 0. Exactly 19 transactions go out, in table order.
- R8: A `start` pulse while `busy` is 0 clears `done` and `error` and runs the table again from entry 0. A `start` pulse while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to run the table again when idle |
| sda_i | input | 1 | Level read back from the data line |
| scl_o | output | 1 | Serial bus clock |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Table walk in progress |
| done | output | 1 | All entries written and acknowledged |
| error | output | 1 | A byte was not acknowledged |

## Verification
The bench plays the bus target. It rebuilds every transaction from the line levels alone and compares the bytes against its own table, in which each entry is different. A byte sent in the wrong order, a shifted bit or the wrong entry therefore stands out. A full run in which every byte is acknowledged checks the frame format, the clock-high timing and the `done` status. Refusals on the address byte of the first entry and on a middle data byte of a later entry check that the block stops after the right transaction and sends nothing more. A `start` pulse during a run has to leave the transaction order untouched, while pulses between runs have to clear the status and restart at entry 0.

// File: rtl/codec_cfg_i2c.sv
module codec_cfg_i2c #(
  parameter int DIV = 8,
  parameter int ENTRIES = 19,
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter logic [ENTRIES*16-1:0] CFG_TABLE = {
    16'h1E00, 16'h1201, 16'h1002, 16'h0E42, 16'h0C00, 16'h0A06, 16'h0812,
    16'h0797, 16'h0597, 16'h0379, 16'h0179, 16'h1A00, 16'h1C00, 16'h2000,
    16'h2200, 16'h2400, 16'h2600, 16'h2800, 16'h1E00}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic error
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int IW = $clog2(ENTRIES);
  localparam logic [CW-1:0] QLAST = CW'(DIV - 1);
  localparam logic [IW-1:0] ILAST = IW'(ENTRIES - 1);
  localparam logic [4:0] STOP_SLOT = 5'd28;

  logic          run, boot;
  logic [CW-1:0] qcnt;
  logic [1:0]    q;
  logic [4:0]    slot, bpos;
  logic [IW-1:0] idx;
  logic [15:0]   word;
  logic [7:0]    cur_byte;
  logic          tick, ack_slot, bitval;

  assign busy     = run;
  assign tick     = run && (qcnt == QLAST);
  assign ack_slot = (slot == 5'd9) || (slot == 5'd18) || (slot == 5'd27);
  assign word     = CFG_TABLE[int'(idx)*16 +: 16];

  always_comb begin
    if (slot <= 5'd9) begin
      cur_byte = {DEV_ADDR, 1'b0};
      bpos     = slot - 5'd1;
    end else if (slot <= 5'd18) begin
      cur_byte = word[15:8];
      bpos     = slot - 5'd10;
    end else begin
      cur_byte = word[7:0];
      bpos     = slot - 5'd19;
    end
    bitval = cur_byte[3'(5'd7 - bpos)];
  end

  always_comb begin
    if (!run) begin
      scl_o  = 1'b1;
      sda_oe = 1'b0;
    end else if (slot == 5'd0) begin
      scl_o  = (q != 2'd3);
      sda_oe = (q >= 2'd2);
    end else if (slot == STOP_SLOT) begin
      scl_o  = (q != 2'd0);
      sda_oe = (q != 2'd3);
    end else begin
      scl_o  = (q == 2'd1) || (q == 2'd2);
      sda_oe = !ack_slot && !bitval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      boot  <= 1'b1;
      qcnt  <= '0;
      q     <= 2'd0;
      slot  <= 5'd0;
      idx   <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else if (!run) begin
      if (start || boot) begin
        run   <= 1'b1;
        boot  <= 1'b0;
        qcnt  <= '0;
        q     <= 2'd0;
        slot  <= 5'd0;
        idx   <= '0;
        done  <= 1'b0;
        error <= 1'b0;
      end
    end else begin
      qcnt <= tick ? '0 : qcnt + 1'b1;
      if (tick) begin
        q <= q + 2'd1;
        if (q == 2'd2 && ack_slot && sda_i) error <= 1'b1;
        if (q == 2'd3) begin
          if (slot == STOP_SLOT) begin
            slot <= 5'd0;
            if (error || idx == ILAST) begin
              run  <= 1'b0;
              done <= !error;
            end else begin
              idx <= idx + 1'b1;
            end
          end else if (ack_slot && error) begin
            slot <= STOP_SLOT;
          end else begin
            slot <= slot + 5'd1;
          end
        end
      end
    end
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));

  // R3
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && (sda_oe != $past(sda_oe))) |-> (slot == 5'd0 || slot == STOP_SLOT));

  // R4
  quarter_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (qcnt <= QLAST));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_o) && ack_slot) |-> !sda_oe);

  // R6
  error_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !done);

  // R6
  error_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && error) |=> (!run || $past(start)));

  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (idx == ILAST && !busy));
endmodule

// File: tb/test_codec_cfg_i2c.sv
module test_codec_cfg_i2c;
  localparam int DIV = 2;
  localparam int ENT = 19;
  localparam logic [6:0] DEV = 7'h1A;

  function automatic logic [ENT*16-1:0] mk_table();
    logic [ENT*16-1:0] t;
    t = '0;
    for (int i = 0; i < ENT; i++)
      t[i*16 +: 16] = {7'(i * 5 + 3), 9'(i * 37 + 11)};
    return t;
  endfunction
  localparam logic [ENT*16-1:0] TBL = mk_table();

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, slave_pull = 1'b0;
  logic scl_o, sda_oe, busy, done, error, sda_line;
  assign sda_line = !(sda_oe || slave_pull);

  codec_cfg_i2c #(.DIV(DIV), .ENTRIES(ENT), .DEV_ADDR(DEV), .CFG_TABLE(TBL)) i_codec_cfg_i2c (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_i(sda_line),
    .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy), .done(done), .error(error));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int frame_no = 0, nack_frame = -1, nack_byte = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  logic prev_scl = 1'b1, prev_sda = 1'b1, in_frame = 1'b0, seen_rise = 1'b0;
  int bitcnt = 0, hi = 0;
  logic [7:0] cur = '0;
  logic [7:0] got[$];

  task automatic end_frame();
    int nexp;
    logic [15:0] w;
    logic [7:0] exp_b[3];
    w = TBL[frame_no*16 +: 16];
    exp_b[0] = {DEV, 1'b0};
    exp_b[1] = w[15:8];
    exp_b[2] = w[7:0];
    nexp = (frame_no == nack_frame) ? nack_byte + 1 : 3;
    chk(got.size() == nexp, "R2 byte count", got.size(), nexp);
    for (int k = 0; k < nexp && k < got.size(); k++)
      chk(got[k] == exp_b[k], "R2 byte value", int'(got[k]), int'(exp_b[k]));
    frame_no++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_scl && scl_o && prev_sda && !sda_line) begin
        chk(!in_frame, "R3 start inside frame", 1, 0);
        in_frame = 1'b1; bitcnt = 0; cur = '0; seen_rise = 1'b0;
        got.delete();
      end else if (prev_scl && scl_o && !prev_sda && sda_line) begin
        if (in_frame) end_frame();
        in_frame = 1'b0; seen_rise = 1'b0;
      end else if (in_frame && !prev_scl && scl_o) begin
        if (bitcnt < 8) cur = {cur[6:0], sda_line};
        bitcnt++;
        if (bitcnt == 9) bitcnt = 0;
        seen_rise = 1'b1; hi = 1;
      end else if (in_frame && prev_scl && !scl_o) begin
        if (seen_rise) chk(hi == 2 * DIV, "R4 scl high time", hi, 2 * DIV);
        seen_rise = 1'b0;
        if (bitcnt == 8) begin
          got.push_back(cur);
          slave_pull = !(frame_no == nack_frame && got.size() - 1 == nack_byte);
        end else begin
          slave_pull = 1'b0;
        end
      end else if (scl_o && seen_rise) begin
        hi++;
      end
      if (in_frame && scl_o && !prev_scl && bitcnt == 0 && seen_rise)
        chk(!sda_oe, "R5 master releases line at ack", int'(sda_oe), 0);
    end
    prev_scl = scl_o;
    prev_sda = sda_line;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    while (!(done || error)) @(negedge clk);
    repeat (4 * DIV * 30) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl in reset", int'(scl_o), 1);
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", int'(sda_oe), 0);
    chk(!busy && !done && !error, "R1 status in reset", int'({busy, done, error}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R1 auto start", int'(busy), 1);

    while (frame_no < 3) @(negedge clk);
    pulse_start();
    chk(busy == 1'b1, "R8 start while busy ignored", int'(busy), 1);
    wait_end();
    chk(done == 1'b1 && error == 1'b0, "R7 done after full table", int'({done, error}), 2);
    chk(frame_no == ENT, "R7 transaction count", frame_no, ENT);
    chk(!busy && scl_o && !sda_oe, "R7 idle bus after done", int'({busy, scl_o, sda_oe}), 2);

    frame_no = 0; nack_frame = 5; nack_byte = 1;
    pulse_start();
    chk(done == 1'b0, "R8 start clears done", int'(done), 0);
    wait_end();
    chk(error == 1'b1 && done == 1'b0, "R6 nack sets error", int'({done, error}), 1);
    chk(frame_no == 6, "R6 no entry after nack", frame_no, 6);
    chk(!busy, "R6 sequence stopped", int'(busy), 0);

    frame_no = 0; nack_frame = 0; nack_byte = 0;
    pulse_start();
    chk(error == 1'b0, "R8 start clears error", int'(error), 0);
    wait_end();
    chk(error == 1'b1 && frame_no == 1, "R6 nack on address byte", frame_no, 1);

    frame_no = 0; nack_frame = -1; nack_byte = -1;
    pulse_start();
    wait_end();
    chk(done == 1'b1 && error == 1'b0, "R8 rerun completes", int'({done, error}), 2);
    chk(frame_no == ENT, "R8 rerun from entry 0", frame_no, ENT);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule